// File: doc/BRIEF.md
# Rotate and Shift Unit with Flag Byte

This block performs the eight single-bit rotate and shift operations of an 8-bit processor's bit-manipulation opcode group. It also builds the full status byte that goes with each operation. A 3-bit operation code selects the variant. The data path takes an operand and the current carry flag. One clock after a valid strobe, it presents the shifted value, the new status byte and a one-cycle done pulse.

The unit has no knowledge of opcode fetch, register or memory addressing, or bus timing. The surrounding core supplies the operand and the operation code, and it writes back the result and the flags. Between operations the registered outputs keep their last values. A consumer may therefore sample them late.

Top module: `rsu_top`

## Requirements
- R1: While `rst_n` is low, `result`, `flags` and `done` are all zero, whatever is driven on the inputs.
- R2: `done` is high in exactly the cycle after a clock edge at which `in_valid` was high, and low otherwise.
- R3: Code 000 rotates left with bit 7 copied into bit 0 and into carry. Code 001 rotates right with bit 0 copied into bit 7 and into carry.
- R4: Code 010 shifts left with `carry_in` entering bit 0. Code 011 shifts right with `carry_in` entering bit 7.
- R5: Code 100 shifts left with 0 entering bit 0. Code 110 shifts left with 1 entering bit 0.
- R6: Code 101 shifts right and keeps bit 7 unchanged. Code 111 shifts right with 0 entering bit 7, so the sign flag is always clear after it.
- R7: Flag bit 7 (sign) equals result bit 7. Flag bit 6 (zero) is 1 exactly when the result is 0x00. Flag bits 5 and 3 equal result bits 5 and 3.
- R8: Flag bit 4 (half carry) and flag bit 1 (subtract) are 0 after every operation.
- R9: Flag bit 2 is 1 when the result has an even number of ones, and 0 otherwise.
- R10: Flag bit 0 (carry) holds the operand bit shifted out: bit 7 for left-moving codes (bit 0 of the code is 0) and bit 0 for right-moving codes.
- R11: A clock edge with `in_valid` low leaves `result` and `flags` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| in_valid | input | 1 | Operation request strobe |
| operand | input | 8 | Value to rotate or shift |
| carry_in | input | 1 | Current carry flag |
| op_sel | input | 3 | Operation code (opcode bits 5:3) |
| result | output | 8 | Registered rotated or shifted value |
| flags | output | 8 | Registered status byte: S,Z,b5,H,b3,P,N,C from bit 7 down to bit 0 |
| done | output | 1 | One-cycle pulse marking new result and flags |

## Verification
The assertions check on every cycle the timing of the done pulse, the holding of outputs across idle edges, and the flag fields that depend on the result alone: sign, zero, the parity bit, the cleared half-carry and subtract bits, and the clear sign after a logical right shift. Only the bench's scenarios can show that each code moves the right bit into the vacated position, that the carry flag takes the bit shifted out, and that `carry_in` matters for the two through-carry codes and no others. To do this, the bench sweeps every code over every operand with both carry values and compares every cycle against its own arithmetic model.

// File: rtl/rsu_pkg.sv
`timescale 1ns/1ps
package rsu_pkg;

  localparam int unsigned DATA_W = 8;
  localparam int unsigned FLAG_W = 8;

  // Operation codes as carried in opcode bits 5:3; bit 0 set means right-moving
  typedef enum logic [2:0] {
    OP_ROT_L_CIRC  = 3'b000,
    OP_ROT_R_CIRC  = 3'b001,
    OP_ROT_L_THRU  = 3'b010,
    OP_ROT_R_THRU  = 3'b011,
    OP_SHL_ZERO    = 3'b100,
    OP_SHR_SIGN    = 3'b101,
    OP_SHL_ONE     = 3'b110,
    OP_SHR_ZERO    = 3'b111
  } rsu_op_e;

  // Status byte bit positions
  localparam int unsigned FB_SIGN   = 7;
  localparam int unsigned FB_ZERO   = 6;
  localparam int unsigned FB_COPY5  = 5;
  localparam int unsigned FB_HALF   = 4;
  localparam int unsigned FB_COPY3  = 3;
  localparam int unsigned FB_PARITY = 2;
  localparam int unsigned FB_SUB    = 1;
  localparam int unsigned FB_CARRY  = 0;

endpackage

// File: rtl/rsu_shift_core.sv
`timescale 1ns/1ps
module rsu_shift_core
  import rsu_pkg::*;
#(
  parameter int unsigned WIDTH = DATA_W
) (
  input  logic [WIDTH-1:0] opnd,
  input  logic             cin,
  input  rsu_op_e          op,
  output logic [WIDTH-1:0] res,
  output logic             cout
);

  localparam int unsigned MSB = WIDTH - 1;

  logic fill_bit;
  logic move_right;

  // Bit entering the vacated position
  always_comb begin
    case (op)
      OP_ROT_L_CIRC: fill_bit = opnd[MSB];
      OP_ROT_R_CIRC: fill_bit = opnd[0];
      OP_ROT_L_THRU: fill_bit = cin;
      OP_ROT_R_THRU: fill_bit = cin;
      OP_SHL_ZERO:   fill_bit = 1'b0;
      OP_SHR_SIGN:   fill_bit = opnd[MSB];
      OP_SHL_ONE:    fill_bit = 1'b1;
      OP_SHR_ZERO:   fill_bit = 1'b0;
      default:       fill_bit = 1'b0;
    endcase
  end

  assign move_right = op[0];

  always_comb begin
    if (move_right) begin
      res  = {fill_bit, opnd[MSB:1]};
      cout = opnd[0];
    end else begin
      res  = {opnd[MSB-1:0], fill_bit};
      cout = opnd[MSB];
    end
  end

endmodule

// File: rtl/rsu_flag_gen.sv
`timescale 1ns/1ps
module rsu_flag_gen
  import rsu_pkg::*;
#(
  parameter int unsigned WIDTH = DATA_W
) (
  input  logic [WIDTH-1:0]  res,
  input  logic              cout,
  output logic [FLAG_W-1:0] flag_byte
);

  localparam int unsigned MSB = WIDTH - 1;

  always_comb begin
    flag_byte            = '0;
    flag_byte[FB_SIGN]   = res[MSB];
    flag_byte[FB_ZERO]   = (res == '0);
    flag_byte[FB_COPY5]  = res[5];
    flag_byte[FB_HALF]   = 1'b0;
    flag_byte[FB_COPY3]  = res[3];
    flag_byte[FB_PARITY] = ~(^res);
    flag_byte[FB_SUB]    = 1'b0;
    flag_byte[FB_CARRY]  = cout;
  end

endmodule

// File: rtl/rsu_top.sv
`timescale 1ns/1ps
module rsu_top
  import rsu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] operand,
  input  logic       carry_in,
  input  logic [2:0] op_sel,
  output logic [7:0] result,
  output logic [7:0] flags,
  output logic       done
);

  logic [DATA_W-1:0] core_res;
  logic              core_cout;
  logic [FLAG_W-1:0] core_flags;

  logic [DATA_W-1:0] res_d,  res_q;
  logic [FLAG_W-1:0] flg_d,  flg_q;
  logic              done_d, done_q;

  rsu_shift_core #(.WIDTH(DATA_W)) u_core (
    .opnd (operand),
    .cin  (carry_in),
    .op   (rsu_op_e'(op_sel)),
    .res  (core_res),
    .cout (core_cout)
  );

  rsu_flag_gen #(.WIDTH(DATA_W)) u_flags (
    .res       (core_res),
    .cout      (core_cout),
    .flag_byte (core_flags)
  );

  // Next state: load on request, otherwise hold
  always_comb begin
    res_d  = res_q;
    flg_d  = flg_q;
    done_d = in_valid;
    if (in_valid) begin
      res_d = core_res;
      flg_d = core_flags;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      flg_q  <= '0;
      done_q <= 1'b0;
    end else begin
      res_q  <= res_d;
      flg_q  <= flg_d;
      done_q <= done_d;
    end
  end

  assign result = res_q;
  assign flags  = flg_q;
  assign done   = done_q;

  AST_DONE_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> done); // R2
  AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !done); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(flags))); // R11
  AST_SIGN_ZERO_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flags[FB_SIGN] == result[7] && flags[FB_ZERO] == (result == 8'h00))); // R7
  AST_COPY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flags[FB_COPY5] == result[5] && flags[FB_COPY3] == result[3])); // R7
  AST_HALF_SUB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!flags[FB_HALF] && !flags[FB_SUB])); // R8
  AST_EVEN_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flags[FB_PARITY] == ($countones(result) % 2 == 0))); // R9
  AST_LOGICAL_RIGHT_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == OP_SHR_ZERO) |=> (!flags[FB_SIGN] && !result[7])); // R6

endmodule

// File: tb/tb_rsu_top.sv
`timescale 1ns/1ps
module tb_rsu_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [7:0] operand;
  logic       carry_in;
  logic [2:0] op_sel;
  logic [7:0] result;
  logic [7:0] flags;
  logic       done;

  always #2.5 clk = ~clk;

  rsu_top dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .operand  (operand),
    .carry_in (carry_in),
    .op_sel   (op_sel),
    .result   (result),
    .flags    (flags),
    .done     (done)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  int    exp_res   = 0;
  int    exp_flags = 0;
  int    exp_done  = 0;
  string exp_tag   = "R11";
  bit    exp_new   = 0;

  task automatic check(string tag, int act, int expv);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  // Behavioural model: returns result and shifted-out carry
  function automatic void model(input int op, input int v, input int c,
                                output int r, output int co);
    case (op)
      0: begin co = v / 128;  r = ((v * 2) % 256) + v / 128; end
      1: begin co = v % 2;    r = v / 2 + (v % 2) * 128; end
      2: begin co = v / 128;  r = ((v * 2) % 256) + c; end
      3: begin co = v % 2;    r = v / 2 + c * 128; end
      4: begin co = v / 128;  r = (v * 2) % 256; end
      5: begin co = v % 2;    r = v / 2 + (v / 128) * 128; end
      6: begin co = v / 128;  r = ((v * 2) % 256) + 1; end
      default: begin co = v % 2; r = v / 2; end
    endcase
  endfunction

  function automatic int make_flags(input int r, input int co);
    int ones = 0;
    int f;
    for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
    f = 0;
    if (r >= 128)           f += 128;
    if (r == 0)             f += 64;
    if ((r >> 5) & 1)       f += 32;
    if ((r >> 3) & 1)       f += 8;
    if (ones % 2 == 0)      f += 4;
    if (co != 0)            f += 1;
    return f;
  endfunction

  function automatic string op_tag(input int op);
    case (op)
      0, 1: return "R3";
      2, 3: return "R4";
      4, 6: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic compare_now();
    check("R2 done", int'(done), exp_done);
    if (exp_new) begin
      check({exp_tag, " result"}, int'(result), exp_res);
      check("R7 sign/zero/copies", int'(flags) & 8'hE8, exp_flags & 8'hE8);
      check("R8 half/sub", int'(flags) & 8'h12, exp_flags & 8'h12);
      check("R9 parity", int'(flags) & 8'h04, exp_flags & 8'h04);
      check("R10 carry", int'(flags) & 8'h01, exp_flags & 8'h01);
    end else begin
      check("R11 result hold", int'(result), exp_res);
      check("R11 flags hold", int'(flags), exp_flags);
    end
  endtask

  task automatic step(bit v, int op, int val, int c);
    int r, co;
    @(negedge clk);
    compare_now();
    in_valid = v;
    op_sel   = 3'(op);
    operand  = 8'(val);
    carry_in = c[0];
    if (v) begin
      model(op, val, c, r, co);
      exp_res   = r;
      exp_flags = make_flags(r, co);
      exp_tag   = op_tag(op);
      exp_new   = 1;
      exp_done  = 1;
    end else begin
      exp_new  = 0;
      exp_done = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b1;
    operand  = 8'hA5;
    carry_in = 1'b1;
    op_sel   = 3'd6;
    repeat (3) @(negedge clk);
    check("R1 result", int'(result), 0);
    check("R1 flags", int'(flags), 0);
    check("R1 done", int'(done), 0);
    in_valid = 1'b0;
    rst_n    = 1'b1;

    // Directed corner cases
    step(1, 7, 8'h80, 1);   // logical right, sign cleared
    step(1, 5, 8'h80, 0);   // arithmetic right keeps sign
    step(1, 6, 8'h00, 0);   // forced one into bit 0
    step(1, 4, 8'h80, 0);   // zero result with carry out
    step(0, 0, 8'hFF, 1);   // idle: hold
    step(0, 3, 8'h11, 0);
    step(1, 2, 8'h00, 1);   // carry enters bit 0
    step(1, 3, 8'h01, 0);   // zero result, carry out
    step(1, 0, 8'h81, 0);
    step(1, 1, 8'h01, 1);

    // Exhaustive sweep with periodic idle cycles
    for (int op = 0; op < 8; op++) begin
      for (int c = 0; c < 2; c++) begin
        for (int v = 0; v < 256; v++) begin
          step(1, op, v, c);
          if (v % 37 == 5) step(0, (op + 3) % 8, 255 - v, 1 - c);
        end
      end
    end

    // Back-to-back requests then final idle
    step(1, 6, 8'h7F, 0);
    step(1, 5, 8'h01, 1);
    step(0, 0, 8'h00, 0);
    step(0, 0, 8'h00, 0);
    @(negedge clk);
    compare_now();
    summary();
  end

endmodule